// File: doc/BRIEF.md
# Quad I/O Flash Read Responder

This block behaves like the target end of a serial flash during a quad-I/O fast read. It is meant as a synthesizable test partner for a quad-SPI host controller. The responder watches chip select, the serial clock and four IO lines, all sampled by its own system clock. It decodes an 8-clock single-line opcode, then takes a 24-bit address and a mode byte over the four lines. After a fixed number of dummy clocks it returns data nibbles from a small read-only pattern memory and steps the address on its own.

The mode byte decides how the next selection starts. One bit pattern keeps the responder in continuous mode, so the next selection begins directly with the address and skips the opcode. Any other pattern sends it back to normal command decoding. A selection made of eight clocks with all four IO lines high also leaves continuous mode. Other commands, status contents other than a quad-enable input, and program or erase are not modelled.

Top module: `qfr_responder`

## Requirements
- R1: While `rst` is high, and whenever `cs_n` is high, `io_oe` is 0. After reset the responder expects an opcode on the next selection.
- R2: In normal mode the first 8 rising `sck` edges of a selection carry the opcode on `io_in[0]`, most significant bit first. Only the code 8'hEB with `quad_en` = 1 starts a read. Any other code, or `quad_en` = 0, leaves `io_oe` at 0 until deselection.
- R3: The address takes 6 rising edges, one nibble each, most significant nibble first, with `io_in[3]` as the nibble's top bit. The low 8 address bits pick the byte, and bits 23..8 have no effect on the data.
- R4: The mode byte takes 2 rising edges after the address, upper nibble first. Mode bits 5..4 are `io_in[1:0]` of the first mode edge. The value 2'b10 arms continuous mode for the next selection, and any other value clears it. The lower nibble has no effect.
- R5: When continuous mode is armed, the first rising edge of a selection already carries the top address nibble, with no opcode phase.
- R6: After the mode byte come 4 dummy rising edges. Data then follows, one nibble per falling `sck` edge and two per byte, upper nibble first. The host samples each nibble at the next rising edge.
- R7: After each byte the byte index steps by one, wrapping from 8'hFF to 8'h00.
- R8: `io_oe` stays 0 through the opcode, address, mode and dummy phases. It rises only with the first data-output falling edge and drops in the same instant `cs_n` goes high.
- R9: A selection whose first 8 rising edges all see `io_in` = 4'hF clears continuous mode and is otherwise ignored. The next selection decodes an opcode.
- R10: The byte at index a is (a*37 + 90) mod 256 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| quad_en | input | 1 | Quad-enable setting; quad reads are refused while 0 |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| io_in | input | 4 | Values seen on the four IO lines |
| io_out | output | 4 | Nibble driven onto the IO lines |
| io_oe | output | 1 | Drive enable for `io_out`; 0 means high impedance |

## Verification
The assertions check on every cycle that the drive enable is off while deselected and outside the data phase. They also check that a read only passes the opcode phase with quad enable set, that continuous mode can only be armed from the mode phase, and that the byte index steps by exactly one with wrap. Only the bench scenarios show the decoding itself. These cover the nibble and bit ordering of address and opcode, the data values across all 256 indices, the effect of each mode byte on the next selection, and the all-ones exit from continuous mode.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

    localparam int ADDR_BITS = 24;
    localparam int NIB_W     = 4;

    localparam logic [7:0] OPC_QUAD_READ = 8'hEB;
    localparam logic [1:0] ARM_CODE      = 2'b10;

    localparam logic [3:0] CMD_LAST  = 4'd7;
    localparam logic [3:0] ADDR_LAST = 4'(ADDR_BITS / NIB_W - 1);
    localparam logic [3:0] MODE_LAST = 4'd1;
    localparam logic [3:0] RST_EDGES = 4'd8;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic             cs_n;
        logic             sck_rise;
        logic             sck_fall;
        logic [NIB_W-1:0] io;
    } pin_evt_t;

    function automatic logic [7:0] pattern_byte(input logic [31:0] idx,
                                                input logic [31:0] mult,
                                                input logic [31:0] seed);
        return 8'(idx * mult + seed);
    endfunction

endpackage

// File: rtl/qfr_pin_sync.sv
module qfr_pin_sync
    import qfr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [NIB_W-1:0] io_in,
    output pin_evt_t         evt
);
    localparam int W = NIB_W + 2;
    localparam logic [W-1:0] IDLE_V = {1'b1, 1'b0, {NIB_W{1'b0}}};

    // cs_n, sck and io travel in one chain so they stay aligned
    logic [STAGES-1:0][W-1:0] chain;
    logic                     sck_prev;
    logic [W-1:0]             tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_V;
            sck_prev <= 1'b0;
        end else begin
            chain[0] <= {cs_n, sck, io_in};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_prev <= tail[W-2];
        end
    end

    assign tail         = chain[STAGES-1];
    assign evt.cs_n     = tail[W-1];
    assign evt.sck_rise = tail[W-2] & ~sck_prev;
    assign evt.sck_fall = ~tail[W-2] & sck_prev;
    assign evt.io       = tail[NIB_W-1:0];

endmodule

// File: rtl/qfr_rom.sv
module qfr_rom
    import qfr_pkg::*;
#(
    parameter int AW   = 8,
    parameter int MULT = 37,
    parameter int SEED = 90
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    assign data = pattern_byte(32'(addr), 32'(MULT), 32'(SEED));
endmodule

// File: rtl/qfr_ctrl.sv
module qfr_ctrl
    import qfr_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int DUMMY_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quad_en,
    input  pin_evt_t          evt,
    input  logic [7:0]        rd_byte,
    output phase_e            state,
    output logic              armed,
    output logic [MEM_AW-1:0] ptr,
    output logic              drive,
    output logic [NIB_W-1:0]  nib_out
);
    localparam logic [3:0] DUMMY_LAST = 4'(DUMMY_CLKS - 1);

    logic [3:0]           cnt;
    logic [3:0]           sel_cnt;
    logic                 ones_ok;
    logic [7:0]           cmd;
    logic [ADDR_BITS-1:0] addr;
    logic [1:0]           m54;
    logic                 hi_nib;

    logic [7:0]           cmd_nx;
    logic [ADDR_BITS-1:0] addr_nx;
    logic                 exit_seq;

    assign cmd_nx   = 8'({cmd, evt.io[0]});
    assign addr_nx  = ADDR_BITS'({addr, evt.io});
    assign exit_seq = (sel_cnt == RST_EDGES - 4'd1) && ones_ok && (evt.io == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_CMD;
            armed   <= 1'b0;
            cnt     <= '0;
            sel_cnt <= '0;
            ones_ok <= 1'b1;
            cmd     <= '0;
            addr    <= '0;
            m54     <= '0;
            ptr     <= '0;
            hi_nib  <= 1'b1;
            drive   <= 1'b0;
            nib_out <= '0;
        end else if (evt.cs_n) begin
            state   <= armed ? ST_ADDR : ST_CMD;
            cnt     <= '0;
            sel_cnt <= '0;
            ones_ok <= 1'b1;
            hi_nib  <= 1'b1;
            drive   <= 1'b0;
        end else begin
            if (evt.sck_rise) begin
                if (sel_cnt != RST_EDGES) sel_cnt <= sel_cnt + 4'd1;
                if (evt.io != '1) ones_ok <= 1'b0;
                if (exit_seq) begin
                    armed <= 1'b0;
                    state <= ST_SKIP;
                end else begin
                    unique case (state)
                        ST_CMD: begin
                            cmd <= cmd_nx;
                            if (cnt == CMD_LAST) begin
                                cnt   <= '0;
                                state <= (cmd_nx == OPC_QUAD_READ && quad_en) ? ST_ADDR : ST_SKIP;
                            end else begin
                                cnt <= cnt + 4'd1;
                            end
                        end
                        ST_ADDR: begin
                            addr <= addr_nx;
                            if (cnt == ADDR_LAST) begin
                                cnt   <= '0;
                                state <= ST_MODE;
                            end else begin
                                cnt <= cnt + 4'd1;
                            end
                        end
                        ST_MODE: begin
                            if (cnt == MODE_LAST) begin
                                cnt   <= '0;
                                armed <= (m54 == ARM_CODE);
                                state <= ST_DUMMY;
                            end else begin
                                m54 <= evt.io[1:0];
                                cnt <= cnt + 4'd1;
                            end
                        end
                        ST_DUMMY: begin
                            if (cnt == DUMMY_LAST) begin
                                cnt    <= '0;
                                ptr    <= addr[MEM_AW-1:0];
                                hi_nib <= 1'b1;
                                state  <= ST_DATA;
                            end else begin
                                cnt <= cnt + 4'd1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (evt.sck_fall && state == ST_DATA) begin
                drive   <= 1'b1;
                nib_out <= hi_nib ? rd_byte[7:4] : rd_byte[3:0];
                hi_nib  <= ~hi_nib;
                if (!hi_nib) ptr <= ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qfr_responder.sv
module qfr_responder
    import qfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MEM_AW      = 8,
    parameter int DUMMY_CLKS  = 4,
    parameter int PAT_MULT    = 37,
    parameter int PAT_SEED    = 90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       quad_en,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic       io_oe
);
    pin_evt_t          evt;
    phase_e            state_w;
    logic              armed_w;
    logic [MEM_AW-1:0] ptr_w;
    logic [7:0]        rd_byte;
    logic              drive_w;

    qfr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .sck   (sck),
        .io_in (io_in),
        .evt   (evt)
    );

    qfr_rom #(.AW(MEM_AW), .MULT(PAT_MULT), .SEED(PAT_SEED)) i_rom (
        .addr (ptr_w),
        .data (rd_byte)
    );

    qfr_ctrl #(.MEM_AW(MEM_AW), .DUMMY_CLKS(DUMMY_CLKS)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .quad_en (quad_en),
        .evt     (evt),
        .rd_byte (rd_byte),
        .state   (state_w),
        .armed   (armed_w),
        .ptr     (ptr_w),
        .drive   (drive_w),
        .nib_out (io_out)
    );

    // raw select gates the enable so the lines release without sync delay
    assign io_oe = drive_w & ~cs_n;

endmodule

// File: rtl/qfr_checker.sv
module qfr_checker
    import qfr_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              quad_en,
    input logic              io_oe,
    input phase_e            state,
    input logic              armed,
    input logic [MEM_AW-1:0] ptr
);
    // R8
    hiz_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !io_oe);

    // R8
    drive_in_data_only_chk: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> state == ST_DATA);

    // R2
    qe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && $past(state) == ST_CMD) |-> $past(quad_en));

    // R4
    arm_from_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(state) == ST_MODE);

    // R7
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_DATA && ptr != $past(ptr))
            |-> ptr == $past(ptr) + 1'b1);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!io_oe && !armed));

endmodule

bind qfr_responder qfr_checker #(.MEM_AW(MEM_AW)) i_qfr_checker (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .quad_en (quad_en),
    .io_oe   (io_oe),
    .state   (state_w),
    .armed   (armed_w),
    .ptr     (ptr_w)
);

// File: tb/test_qfr_responder.sv
module test_qfr_responder;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       quad_en = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic [3:0] io_in = 4'h0;
    logic [3:0] io_out;
    logic       io_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    qfr_responder i_qfr_responder (
        .clk     (clk),
        .rst     (rst),
        .quad_en (quad_en),
        .cs_n    (cs_n),
        .sck     (sck),
        .io_in   (io_in),
        .io_out  (io_out),
        .io_oe   (io_oe)
    );

    function automatic logic [7:0] exp_byte(input int idx);
        return 8'(((idx % 256) * 37 + 90) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_out(input logic [3:0] v);
        io_in = v;
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic clk_rd(output logic [3:0] v, output logic oe);
        tick(HALF);
        v  = io_out;
        oe = io_oe;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic select();
        cs_n = 1'b0;
        io_in = 4'h0;
        tick(HALF);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        #1;
        check(io_oe == 1'b0, "R8 release on deselect", int'(io_oe), 0);
        tick(6);
    endtask

    task automatic send_head(input bit with_op, input logic [7:0] op,
                             input logic [23:0] a, input logic [7:0] m);
        if (with_op)
            for (int i = 7; i >= 0; i--) clk_out({3'b000, op[i]});
        for (int n = 5; n >= 0; n--) clk_out(a[n*4 +: 4]);
        clk_out(m[7:4]);
        clk_out(m[3:0]);
    endtask

    // full read: expects nbytes of pattern data starting at a[7:0]
    task automatic quad_read(input bit with_op, input logic [23:0] a,
                             input logic [7:0] m, input int nbytes, input string req);
        logic [3:0] h, l;
        logic       oh, ol;
        logic [7:0] e;
        select();
        send_head(with_op, 8'hEB, a, m);
        for (int d = 0; d < 4; d++) begin
            io_in = 4'h0;
            tick(HALF);
            if (d == 0 || d == 3)
                check(io_oe == 1'b0, "R8 hi-Z in dummy", int'(io_oe), 0);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        for (int b = 0; b < nbytes; b++) begin
            clk_rd(h, oh);
            clk_rd(l, ol);
            e = exp_byte(int'(a[7:0]) + b);
            check(oh && ol && {h, l} == e, req, {oh, ol, h, l}, {2'b11, e});
        end
        deselect();
    endtask

    // a selection that must never drive the lines
    task automatic silent_read(input bit with_op, input logic [7:0] op,
                               input logic [23:0] a, input string req);
        logic [3:0] v;
        logic       oe;
        logic       any_oe;
        any_oe = 1'b0;
        select();
        send_head(with_op, op, a, 8'h00);
        for (int k = 0; k < 12; k++) begin
            clk_rd(v, oe);
            any_oe |= oe;
        end
        check(!any_oe, req, int'(any_oe), 0);
        deselect();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        logic       oe;
        logic       any_oe;
        tick(5);
        check(io_oe == 1'b0, "R1 oe low in reset", int'(io_oe), 0);
        rst = 1'b0;
        tick(3);
        check(io_oe == 1'b0, "R1 oe low after reset", int'(io_oe), 0);

        // R2 R3 R6 R10: plain read, opcode phase, four bytes
        quad_read(1'b1, 24'h000010, 8'h00, 4, "R6 normal read data");
        // R3 R7: high address bits ignored, wrap FE FF 00 01
        quad_read(1'b1, 24'hABCDFE, 8'hFF, 4, "R7 wrap across FF");
        // R2: wrong opcode never drives
        silent_read(1'b1, 8'h0B, 24'h000020, "R2 other opcode silent");
        // R2: quad enable low refuses EB
        quad_en = 1'b0;
        silent_read(1'b1, 8'hEB, 24'h000020, "R2 quad_en low silent");
        quad_en = 1'b1;
        // R2: opcode still expected afterwards (not armed)
        quad_read(1'b1, 24'h000033, 8'h00, 1, "R2 opcode after refusal");

        // R4 R5: arm with 0xA5, then sweep every index without opcode
        quad_read(1'b1, 24'h000000, 8'hA5, 1, "R4 arming read");
        for (int a = 0; a < 256; a++)
            quad_read(1'b0, {16'h5A3C, 8'(a)}, 8'h20, 1, "R5 R10 armed sweep");

        // R4: mode bits 11 clear continuous mode; opcode read next
        quad_read(1'b0, 24'h000077, 8'h30, 2, "R4 last armed read");
        quad_read(1'b1, 24'h0000C1, 8'h00, 2, "R4 opcode after clear");

        // R4: low nibble of mode byte has no effect (0x2F arms)
        quad_read(1'b1, 24'h000042, 8'h2F, 1, "R4 arm with 2F");
        quad_read(1'b0, 24'h000043, 8'h9F, 1, "R4 armed after 2F");
        // 0x9F: bits 5..4 = 01 -> cleared
        quad_read(1'b1, 24'h000044, 8'h00, 1, "R4 cleared by 9F");

        // R9: arm, then eight all-ones edges exit continuous mode
        quad_read(1'b1, 24'h000050, 8'h20, 1, "R9 arm before exit");
        any_oe = 1'b0;
        select();
        for (int k = 0; k < 8; k++) clk_out(4'hF);
        for (int k = 0; k < 12; k++) begin
            clk_rd(v, oe);
            any_oe |= oe;
        end
        check(!any_oe, "R9 exit selection silent", int'(any_oe), 0);
        deselect();
        quad_read(1'b1, 24'h0000E7, 8'h00, 3, "R9 opcode after exit");

        // R8: deselect in the middle of a byte releases at once
        select();
        send_head(1'b1, 8'hEB, 24'h000090, 8'h00);
        for (int d = 0; d < 4; d++) clk_out(4'h0);
        clk_rd(v, oe);
        check(oe && v == exp_byte(8'h90) >> 4, "R8 first nibble driven",
              {oe, v}, {1'b1, exp_byte(8'h90) >> 4});
        deselect();
        quad_read(1'b1, 24'h000091, 8'h00, 1, "R8 read after abort");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule